// File: doc/BRIEF.md
# Automatic Frequency Offset Controller

This block owns the frequency-offset correction that is applied to a receiver synthesizer's channel word. A measurement core outside the block reports a signed frequency error together with a one-cycle completion pulse. The block groups these pulses into measurement cycles, qualifies each cycle against a valid-data indicator, and decides when the correction register takes a new value. It then limits the stored correction, gates it, and adds it to a range-checked 12-bit channel word to form the synthesizer control word.

There are four latching policies. In the manual policy software raises a strobe bit. In the other three policies updates are automatic: the first policy latches once after reset, the second tracks the signal and drops the correction when the signal goes away, and the third tracks the signal and keeps its last value. An automatic update needs two consecutive measurement cycles, both with the data indicator held high throughout, that report the same result. A toggle flag and a same-result flag make cycle progress visible.

Top module: `afc_offset_ctrl`

## Requirements
- R1: Control field `ctrl[7:6]`=00 (manual): a 0-to-1 change of the strobe bit `ctrl[3]`, seen on consecutive clock edges, copies the most recent completed measurement result into the correction register. Without such a change the register keeps its value, even when new measurements complete.
- R2: `ctrl[7:6]`=01 (once): the first qualified result after reset is latched. After that the register no longer changes while this policy stays selected.
- R3: `ctrl[7:6]`=10 (track): every qualified result is latched. While `data_valid` is low the register is cleared to zero.
- R4: `ctrl[7:6]`=11 (hold): every qualified result is latched. A low `data_valid` leaves the register unchanged.
- R5: A result is qualified when `data_valid` was high for the whole of its measurement cycle, the previous cycle was also valid in the same sense, and both cycles reported the same value.
- R6: The range field `ctrl[5:4]` saturates the reported correction: 00 gives no limit, 01 gives ±4, 10 gives ±2 and 11 gives ±1 steps.
- R7: When the output-enable bit `ctrl[1]` is 0, `offset_out` is zero. When it is 1, `offset_out` is the limited correction.
- R8: When the add-enable bit `ctrl[0]` is 1, `synth_word` is the channel word plus the sign-extended `offset_out`, modulo 4096. When it is 0, `synth_word` equals the channel word.
- R9: `cyc_toggle` inverts at the end of every measurement cycle. At each cycle end `cyc_same` becomes 1 if that cycle's result equals the previous cycle's result, and 0 otherwise.
- R10: With the fine bit `ctrl[2]` at 0, every `meas_done` pulse ends a cycle. With the fine bit at 1, only every fourth pulse ends a cycle, counted from the moment fine mode was entered.
- R11: A channel write with data from 96 to 3903 inclusive is stored. A write outside that range is ignored, and the previous channel word is kept.
- R12: After reset the correction is 0, the channel word is 1000, and both `cyc_toggle` and `cyc_same` are 0.
- R13: `offset_rpt` carries the sign bit of `offset_out` in bit 5 and the five low bits of `offset_out` in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| offset_meas | input | 7 | Signed measured frequency error from the core |
| meas_done | input | 1 | One-cycle pulse marking a completed measurement |
| data_valid | input | 1 | Valid-data indicator |
| ctrl | input | 8 | Policy[7:6], range[5:4], strobe[3], fine[2], output enable[1], add enable[0] |
| chan_we | input | 1 | Channel word write pulse |
| chan_wdata | input | 12 | Channel word write data |
| offset_out | output | 7 | Limited and gated signed correction |
| offset_rpt | output | 6 | Sign bit plus five low bits of the correction |
| synth_word | output | 12 | Channel word with the correction added |
| cyc_toggle | output | 1 | Inverts once per measurement cycle |
| cyc_same | output | 1 | Last two results matched |

## Verification
The correction register, the channel word, the toggle and the same flag change on the clock edge that samples the causing `meas_done`, strobe, `data_valid` or write input. They are therefore due one edge after the stimulus is applied. `offset_out`, `offset_rpt` and `synth_word` follow the range, output-enable and add-enable bits with no register in the path. The bench drives every input on a falling edge and reads results on the next falling edge, which is exactly one rising edge later. The range, gating and adder outputs are swept over all 128 correction values and all control combinations.

// File: rtl/afc_pkg.sv
package afc_pkg;

   typedef enum logic [1:0] {
      AFC_MANUAL = 2'b00,
      AFC_ONCE   = 2'b01,
      AFC_TRACK  = 2'b10,
      AFC_HOLD   = 2'b11
   } afc_mode_e;

   typedef struct packed {
      afc_mode_e  mode;
      logic [1:0] rlim;
      logic       strobe;
      logic       fine;
      logic       out_en;
      logic       add_en;
   } afc_cfg_t;

endpackage

// File: rtl/afc_cycle_track.sv
module afc_cycle_track
   import afc_pkg::*;
#(
   parameter int OFS_W    = 7,
   parameter int FINE_DIV = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  afc_cfg_t                cfg,
   input  logic                    meas_done,
   input  logic                    vdi,
   input  logic signed [OFS_W-1:0] meas_val,
   output logic                    cycle_end,
   output logic                    qualify,
   output logic signed [OFS_W-1:0] last_res,
   output logic                    toggle,
   output logic                    same
);

   logic low_seen;
   logic have_res;
   logic last_valid;
   logic valid_now;
   logic match;

   generate
      if (FINE_DIV > 1) begin : g_presc
         localparam int CNT_W = $clog2(FINE_DIV);
         localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FINE_DIV - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!cfg.fine)
               cnt <= '0;
            else if (meas_done)
               cnt <= (cnt == CNT_TOP) ? '0 : cnt + 1'b1;
         end

         assign cycle_end = meas_done && (!cfg.fine || (cnt == CNT_TOP));

         p_fine_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.fine && meas_done && cnt != CNT_TOP) |=> $stable(toggle));
      end else begin : g_direct
         assign cycle_end = meas_done;
      end
   endgenerate

   assign valid_now = vdi && !low_seen;
   assign match     = have_res && (meas_val == last_res);
   assign qualify   = cycle_end && valid_now && last_valid && match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_res   <= '0;
         have_res   <= 1'b0;
         last_valid <= 1'b0;
         low_seen   <= 1'b0;
         toggle     <= 1'b0;
         same       <= 1'b0;
      end else if (cycle_end) begin
         last_res   <= meas_val;
         have_res   <= 1'b1;
         last_valid <= valid_now;
         low_seen   <= 1'b0;
         toggle     <= ~toggle;
         same       <= match;
      end else if (!vdi) begin
         low_seen   <= 1'b1;
      end
   end

   p_toggle_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> (toggle != $past(toggle)));
   p_toggle_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cycle_end |=> $stable(toggle));
   p_qual_vdi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      qualify |-> vdi);

endmodule

// File: rtl/afc_offset_reg.sv
module afc_offset_reg
   import afc_pkg::*;
#(
   parameter int OFS_W = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  afc_cfg_t                cfg,
   input  logic                    vdi,
   input  logic                    qualify,
   input  logic signed [OFS_W-1:0] meas_val,
   input  logic signed [OFS_W-1:0] last_res,
   output logic signed [OFS_W-1:0] ofs_q
);

   logic st_q;
   logic once_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q     <= '0;
         st_q      <= 1'b0;
         once_done <= 1'b0;
      end else begin
         st_q <= cfg.strobe;
         unique case (cfg.mode)
            AFC_MANUAL: begin
               if (cfg.strobe && !st_q)
                  ofs_q <= last_res;
            end
            AFC_ONCE: begin
               if (qualify && !once_done) begin
                  ofs_q     <= meas_val;
                  once_done <= 1'b1;
               end
            end
            AFC_TRACK: begin
               if (!vdi)
                  ofs_q <= '0;
               else if (qualify)
                  ofs_q <= meas_val;
            end
            AFC_HOLD: begin
               if (qualify)
                  ofs_q <= meas_val;
            end
            default: ;
         endcase
      end
   end

   p_manual_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == AFC_MANUAL && !cfg.strobe) |=> $stable(ofs_q));
   p_once_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == AFC_ONCE && once_done) |=> $stable(ofs_q));
   p_track_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == AFC_TRACK && !vdi) |=> (ofs_q == '0));
   p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.mode == AFC_HOLD && !qualify) |=> $stable(ofs_q));

endmodule

// File: rtl/afc_chan_reg.sv
module afc_chan_reg #(
   parameter int CHAN_W   = 12,
   parameter int CHAN_MIN = 96,
   parameter int CHAN_MAX = 3903,
   parameter int CHAN_RST = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CHAN_W-1:0] wdata,
   output logic [CHAN_W-1:0] chan_q
);

   localparam logic [CHAN_W-1:0] LO_W  = CHAN_W'(CHAN_MIN);
   localparam logic [CHAN_W-1:0] HI_W  = CHAN_W'(CHAN_MAX);
   localparam logic [CHAN_W-1:0] RST_W = CHAN_W'(CHAN_RST);

   logic in_range;
   assign in_range = (wdata >= LO_W) && (wdata <= HI_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chan_q <= RST_W;
      else if (we && in_range)
         chan_q <= wdata;
   end

   p_chan_bounds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_q >= LO_W) && (chan_q <= HI_W));
   p_chan_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (wdata < LO_W || wdata > HI_W)) |=> $stable(chan_q));

endmodule

// File: rtl/afc_out_stage.sv
module afc_out_stage
   import afc_pkg::*;
#(
   parameter int OFS_W   = 7,
   parameter int CHAN_W  = 12,
   parameter int RPT_LOW = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  afc_cfg_t                cfg,
   input  logic signed [OFS_W-1:0] ofs_q,
   input  logic [CHAN_W-1:0]       chan_q,
   output logic signed [OFS_W-1:0] ofs_out,
   output logic [RPT_LOW:0]        ofs_rpt,
   output logic [CHAN_W-1:0]       freq_out
);

   localparam int EXT_W = CHAN_W - OFS_W;

   logic signed [OFS_W-1:0] lim_mag;
   logic signed [OFS_W-1:0] ofs_lim;
   logic [CHAN_W-1:0]       ofs_ext;

   always_comb begin
      unique case (cfg.rlim)
         2'b01:   lim_mag = OFS_W'(4);
         2'b10:   lim_mag = OFS_W'(2);
         2'b11:   lim_mag = OFS_W'(1);
         default: lim_mag = {1'b0, {(OFS_W-1){1'b1}}};
      endcase
   end

   always_comb begin
      if (cfg.rlim == 2'b00)
         ofs_lim = ofs_q;
      else if (ofs_q > lim_mag)
         ofs_lim = lim_mag;
      else if (ofs_q < -lim_mag)
         ofs_lim = -lim_mag;
      else
         ofs_lim = ofs_q;
   end

   assign ofs_out  = cfg.out_en ? ofs_lim : '0;
   assign ofs_rpt  = {ofs_out[OFS_W-1], ofs_out[RPT_LOW-1:0]};
   assign ofs_ext  = {{EXT_W{ofs_out[OFS_W-1]}}, ofs_out};
   assign freq_out = cfg.add_en ? (chan_q + ofs_ext) : chan_q;

   p_unit_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.rlim == 2'b11) |-> (ofs_out >= -1 && ofs_out <= 1));
   p_gate_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.out_en |-> (freq_out == chan_q));
   p_add_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.add_en |-> (freq_out == chan_q));

endmodule

// File: rtl/afc_offset_ctrl.sv
module afc_offset_ctrl
   import afc_pkg::*;
#(
   parameter int OFS_W    = 7,
   parameter int RPT_LOW  = 5,
   parameter int CHAN_W   = 12,
   parameter int CHAN_MIN = 96,
   parameter int CHAN_MAX = 3903,
   parameter int CHAN_RST = 1000,
   parameter int FINE_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFS_W-1:0]  offset_meas,
   input  logic              meas_done,
   input  logic              data_valid,
   input  logic [7:0]        ctrl,
   input  logic              chan_we,
   input  logic [CHAN_W-1:0] chan_wdata,
   output logic [OFS_W-1:0]  offset_out,
   output logic [RPT_LOW:0]  offset_rpt,
   output logic [CHAN_W-1:0] synth_word,
   output logic              cyc_toggle,
   output logic              cyc_same
);

   generate
      if (OFS_W < 4 || OFS_W >= CHAN_W) begin : g_bad_ofs
         $error("afc_offset_ctrl: OFS_W must lie in 4..CHAN_W-1");
      end
      if (RPT_LOW < 1 || RPT_LOW >= OFS_W) begin : g_bad_rpt
         $error("afc_offset_ctrl: RPT_LOW must lie in 1..OFS_W-1");
      end
      if (CHAN_MIN > CHAN_MAX || CHAN_RST < CHAN_MIN || CHAN_RST > CHAN_MAX) begin : g_bad_chan
         $error("afc_offset_ctrl: channel limits inconsistent");
      end
      if (FINE_DIV < 1) begin : g_bad_div
         $error("afc_offset_ctrl: FINE_DIV must be positive");
      end
   endgenerate

   afc_cfg_t                cfg;
   logic signed [OFS_W-1:0] meas_s;
   logic signed [OFS_W-1:0] last_res;
   logic signed [OFS_W-1:0] ofs_q;
   logic signed [OFS_W-1:0] ofs_o;
   logic [CHAN_W-1:0]       chan_q;
   logic                    cycle_end;
   logic                    qualify;

   assign cfg    = afc_cfg_t'(ctrl);
   assign meas_s = $signed(offset_meas);

   afc_cycle_track #(.OFS_W(OFS_W), .FINE_DIV(FINE_DIV)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg),
      .meas_done (meas_done),
      .vdi       (data_valid),
      .meas_val  (meas_s),
      .cycle_end (cycle_end),
      .qualify   (qualify),
      .last_res  (last_res),
      .toggle    (cyc_toggle),
      .same      (cyc_same)
   );

   afc_offset_reg #(.OFS_W(OFS_W)) u_ofs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg),
      .vdi      (data_valid),
      .qualify  (qualify),
      .meas_val (meas_s),
      .last_res (last_res),
      .ofs_q    (ofs_q)
   );

   afc_chan_reg #(
      .CHAN_W(CHAN_W), .CHAN_MIN(CHAN_MIN), .CHAN_MAX(CHAN_MAX), .CHAN_RST(CHAN_RST)
   ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (chan_we),
      .wdata  (chan_wdata),
      .chan_q (chan_q)
   );

   afc_out_stage #(.OFS_W(OFS_W), .CHAN_W(CHAN_W), .RPT_LOW(RPT_LOW)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg),
      .ofs_q    (ofs_q),
      .chan_q   (chan_q),
      .ofs_out  (ofs_o),
      .ofs_rpt  (offset_rpt),
      .freq_out (synth_word)
   );

   assign offset_out = ofs_o;

   p_rst_toggle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cyc_toggle == 1'b0 && cyc_same == 1'b0));
   p_cycle_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_done && !cycle_end) |=> $stable(cyc_toggle));

endmodule

// File: tb/afc_offset_ctrl_tb.sv
module afc_offset_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  offset_meas = '0;
   logic        meas_done = 1'b0;
   logic        data_valid = 1'b0;
   logic [7:0]  ctrl = '0;
   logic        chan_we = 1'b0;
   logic [11:0] chan_wdata = '0;
   logic [6:0]  offset_out;
   logic [5:0]  offset_rpt;
   logic [11:0] synth_word;
   logic        cyc_toggle;
   logic        cyc_same;

   int checks = 0;
   int errors = 0;
   int exp_chan = 1000;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   afc_offset_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .offset_meas(offset_meas), .meas_done(meas_done),
      .data_valid(data_valid), .ctrl(ctrl), .chan_we(chan_we), .chan_wdata(chan_wdata),
      .offset_out(offset_out), .offset_rpt(offset_rpt), .synth_word(synth_word),
      .cyc_toggle(cyc_toggle), .cyc_same(cyc_same)
   );

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ofs_val();
      int v;
      v = $signed(offset_out);
      return v;
   endfunction

   function automatic int sat(input int v, input int rl);
      int m;
      if (rl == 0) return v;
      m = (rl == 1) ? 4 : ((rl == 2) ? 2 : 1);
      if (v > m) return m;
      if (v < -m) return -m;
      return v;
   endfunction

   function automatic logic [7:0] mk(input int mode, input int rl, input bit st,
                                     input bit fine, input bit oe, input bit en);
      return {mode[1:0], rl[1:0], st, fine, oe, en};
   endfunction

   task automatic pulse(input int v);
      offset_meas = v[6:0];
      meas_done = 1'b1;
      @(negedge clk);
      meas_done = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_chan = 1000;
      @(negedge clk);
   endtask

   task automatic chan_write(input int d);
      chan_wdata = d[11:0];
      chan_we = 1'b1;
      @(negedge clk);
      chan_we = 1'b0;
      if (d >= 96 && d <= 3903) exp_chan = d;
   endtask

   task automatic strobe_latch(input int rl, input bit oe, input bit en);
      ctrl = mk(0, rl, 1'b1, 1'b0, oe, en);
      @(negedge clk);
      ctrl = mk(0, rl, 1'b0, 1'b0, oe, en);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired before the sequence completed");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      bit t0;
      ctrl = mk(0, 0, 0, 0, 0, 0);
      do_reset();

      // R12 reset state
      check_eq("R12 offset", ofs_val(), 0);
      check_eq("R12 chan", int'(synth_word), 1000);
      check_eq("R12 toggle", int'(cyc_toggle), 0);
      check_eq("R12 same", int'(cyc_same), 0);

      // R11 channel range
      ctrl = mk(0, 0, 0, 0, 1, 0);
      chan_write(95);   check_eq("R11 below min", int'(synth_word), exp_chan);
      chan_write(96);   check_eq("R11 min", int'(synth_word), exp_chan);
      chan_write(3903); check_eq("R11 max", int'(synth_word), exp_chan);
      chan_write(3904); check_eq("R11 above max", int'(synth_word), exp_chan);
      chan_write(4095); check_eq("R11 top code", int'(synth_word), exp_chan);
      chan_write(0);    check_eq("R11 zero", int'(synth_word), exp_chan);
      chan_write(2000); check_eq("R11 mid", int'(synth_word), exp_chan);

      // R1 manual strobe and no change without it
      ctrl = mk(0, 0, 0, 0, 1, 1);
      pulse(9);
      check_eq("R1 before strobe", ofs_val(), 0);
      strobe_latch(0, 1, 1);
      check_eq("R1 after strobe", ofs_val(), 9);
      pulse(-3);
      @(negedge clk);
      check_eq("R1 no edge keeps", ofs_val(), 9);
      ctrl = mk(0, 0, 1, 0, 1, 1);
      @(negedge clk);
      check_eq("R1 rising edge", ofs_val(), -3);
      pulse(20);
      @(negedge clk);
      check_eq("R1 strobe held high keeps", ofs_val(), -3);
      ctrl = mk(0, 0, 0, 0, 1, 1);
      @(negedge clk);

      // R6 R7 R8 R13 sweep over every offset and control combination
      for (int v = -64; v < 64; v++) begin
         pulse(v);
         strobe_latch(0, 1, 1);
         for (int rl = 0; rl < 4; rl++) begin
            for (int g = 0; g < 4; g++) begin
               int eo;
               int ef;
               int er;
               ctrl = mk(0, rl, 1'b0, 1'b0, g[1], g[0]);
               @(negedge clk);
               eo = g[1] ? sat(v, rl) : 0;
               ef = g[0] ? ((exp_chan + eo) & 4095) : exp_chan;
               er = ((eo < 0) ? 32 : 0) + (eo & 31);
               check_eq(rl == 0 ? "R7 offset gate" : "R6 range limit", ofs_val(), eo);
               check_eq("R8 synth word", int'(synth_word), ef);
               check_eq("R13 report", int'(offset_rpt), er);
            end
         end
      end

      // R9 toggle and same flag
      ctrl = mk(0, 0, 0, 0, 1, 1);
      t0 = cyc_toggle;
      pulse(5);
      check_eq("R9 toggle flips", int'(cyc_toggle), int'(!t0));
      pulse(5);
      check_eq("R9 toggle flips again", int'(cyc_toggle), int'(t0));
      check_eq("R9 same high", int'(cyc_same), 1);
      pulse(6);
      check_eq("R9 same low", int'(cyc_same), 0);

      // R10 fine mode divides cycles by four
      ctrl = mk(0, 0, 0, 1, 1, 1);
      @(negedge clk);
      t0 = cyc_toggle;
      pulse(1); check_eq("R10 pulse1", int'(cyc_toggle), int'(t0));
      pulse(1); check_eq("R10 pulse2", int'(cyc_toggle), int'(t0));
      pulse(1); check_eq("R10 pulse3", int'(cyc_toggle), int'(t0));
      pulse(1); check_eq("R10 pulse4", int'(cyc_toggle), int'(!t0));
      ctrl = mk(0, 0, 0, 0, 1, 1);
      @(negedge clk);

      // R3 R5 track mode
      ctrl = mk(2, 0, 0, 0, 1, 1);
      data_valid = 1'b1;
      do_reset();
      pulse(7);  check_eq("R5 single result", ofs_val(), 0);
      pulse(7);  check_eq("R3 update", ofs_val(), 7);
      pulse(9);  check_eq("R5 mismatch", ofs_val(), 7);
      data_valid = 1'b0;
      @(negedge clk);
      check_eq("R3 clear on low", ofs_val(), 0);
      data_valid = 1'b1;

      // R4 R5 hold mode
      ctrl = mk(3, 0, 0, 0, 1, 1);
      do_reset();
      pulse(10); pulse(10);
      check_eq("R4 update", ofs_val(), 10);
      data_valid = 1'b0;
      @(negedge clk);
      data_valid = 1'b1;
      check_eq("R4 hold on low", ofs_val(), 10);
      pulse(12); check_eq("R5 cycle with low", ofs_val(), 10);
      pulse(12); check_eq("R5 prior cycle invalid", ofs_val(), 10);
      pulse(12); check_eq("R4 second update", ofs_val(), 12);

      // R2 once mode
      ctrl = mk(1, 0, 0, 0, 1, 1);
      do_reset();
      pulse(-5); pulse(-5);
      check_eq("R2 first latch", ofs_val(), -5);
      pulse(20); pulse(20);
      check_eq("R2 frozen", ofs_val(), -5);
      data_valid = 1'b0;
      @(negedge clk);
      check_eq("R2 frozen on low", ofs_val(), -5);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule